// File: doc/BRIEF.md
# Multi-Format Serial Audio Input Receiver

This block receives stereo PCM audio from a three-wire serial link: a bit clock, a word-select (left/right) clock and a data line. It always runs as a slave. All three wires pass through synchronisers into a system clock that is at least four times faster than the bit clock. Each rising bit-clock edge found in that domain becomes a single-cycle bit event. One capture engine decodes five framings: LSB-justified at 16, 20 and 24 bits, MSB-justified with a 24-bit slot, and I2S with a 24-bit slot. A 3-bit format code selects the framing.

Decoded samples leave the block as a 24-bit left/right pair with a single-cycle valid strobe, once for every complete frame. LSB-justified words are sign-extended. MSB-justified and I2S words are left-aligned, so shorter data fills the upper bits. The format code is latched only while power-down is asserted. The block also keeps two sticky flags. One reports half-frames that are too short for the latched format. The other reports a bit clock that has stopped.

Top module: `audio_serial_rx`

## Requirements
- R1: Data is MSB first and two's complement, sampled on rising bit-clock edges. Both channels of a frame leave together on `left_o`/`right_o`, and `valid_o` is high for exactly one system cycle per frame.
- R2: Format codes: 0 = 16-bit LSB-justified, 1 = 20-bit LSB-justified, 2 = 24-bit-slot MSB-justified, 3 = 24-bit-slot I2S, 4 = 24-bit LSB-justified; 5, 6 and 7 are reserved.
- R3: LSB-justified: the word-select line is high for left. The sample is the last N bits (N = 16, 20 or 24) before the next word-select change, and it is output sign-extended to 24 bits.
- R4: MSB-justified: the word-select line is high for left. The MSB is sampled on the first bit event after a word-select change, and up to 24 bits are taken. A shorter word (for example 20 bits) is output left-aligned, with zeros below it.
- R5: I2S: the word-select line is low for left. The MSB arrives one bit after the word-select change, and the bit sampled on the change itself is the previous word's LSB. 16-bit words in 16-bit half-frames are accepted and output left-aligned.
- R6: `fmt_sel` is captured only while `pwrdn` is high. A change made while running has no effect until the next power-down.
- R7: With a reserved code latched, no pair is produced, `valid_o` stays low and both sample outputs stay zero.
- R8: A half-frame with fewer bit events than the latched format's minimum sets a sticky `ratio_err_o`. The minimum is 16 for codes 0 and 3, 20 for code 1, and 24 for codes 2 and 4. Only power-down or reset clears the flag.
- R9: While running, `LOSS_CYCLES` system cycles without a bit-clock rising edge set a sticky `clk_loss_o`. Only power-down or reset clears it.
- R10: Reset or power-down clears both sample outputs, `valid_o` and both flags. After the block starts, the half-frame before the first word-select change is discarded, so the first pair needs one complete left half and one complete right half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrdn | input | 1 | Power-down; high holds the block idle and latches the format |
| fmt_sel | input | 3 | Framing code, see R2 |
| sck_in | input | 1 | Serial bit clock (asynchronous) |
| ws_in | input | 1 | Word-select / frame clock (asynchronous) |
| sd_in | input | 1 | Serial data (asynchronous) |
| left_o | output | 24 | Left sample of the last complete frame |
| right_o | output | 24 | Right sample of the last complete frame |
| valid_o | output | 1 | One-cycle strobe when a new pair is presented |
| ratio_err_o | output | 1 | Sticky short half-frame flag |
| clk_loss_o | output | 1 | Sticky stopped bit-clock flag |

## Verification
Five properties hold on every cycle. Valid never lasts two cycles. Power-down silences the outputs and flags. The latched format only moves after power-down. A reserved format keeps the block silent. Both error flags stay set until power-down. The framing itself can only be shown by the bench's scenarios: bit alignment per format, sign extension against left alignment, the I2S LSB carried across the word-select change, and discarding of the first partial half. The same holds for format locking against a live `fmt_sel` change and the exact ratio and timeout thresholds.

// File: rtl/asrx_pkg.sv
`timescale 1ns/1ps
package asrx_pkg;

    localparam int SW = 24;                 // sample width at the outputs
    localparam int NW = $clog2(SW + 1);     // width of a bit count up to SW
    localparam int HW = 8;                  // half-frame length counter width

    localparam logic [2:0] FMT_LSB16 = 3'd0;
    localparam logic [2:0] FMT_LSB20 = 3'd1;
    localparam logic [2:0] FMT_MSB24 = 3'd2;
    localparam logic [2:0] FMT_I2S24 = 3'd3;
    localparam logic [2:0] FMT_LSB24 = 3'd4;

    typedef struct packed {
        logic          primed;     // first bit event seen
        logic          started;    // first word-select change seen
        logic          ws_last;    // word-select at previous bit event
        logic          have_left;  // left word waiting for its partner
        logic [SW-1:0] acc;        // shared capture register
        logic [NW-1:0] nbits;      // bits held in acc (justified modes)
        logic [HW-1:0] hcnt;       // bit events in current half-frame
        logic [SW-1:0] left_hold;
        logic [SW-1:0] left;
        logic [SW-1:0] right;
        logic          valid;
        logic          ratio_err;
    } eng_t;

    function automatic logic fmt_reserved(logic [2:0] f);
        return f > FMT_LSB24;
    endfunction

    function automatic logic fmt_is_lsb(logic [2:0] f);
        return (f == FMT_LSB16) || (f == FMT_LSB20) || (f == FMT_LSB24);
    endfunction

    function automatic logic [NW-1:0] lsb_bits(logic [2:0] f);
        case (f)
            FMT_LSB16: return NW'(16);
            FMT_LSB20: return NW'(20);
            default:   return NW'(SW);
        endcase
    endfunction

    function automatic logic [HW-1:0] min_half(logic [2:0] f);
        case (f)
            FMT_LSB16, FMT_I2S24: return HW'(16);
            FMT_LSB20:            return HW'(20);
            default:              return HW'(SW);
        endcase
    endfunction

    // word-select level that marks the left channel
    function automatic logic left_ws(logic [2:0] f);
        return f != FMT_I2S24;
    endfunction

    function automatic logic [SW-1:0] sext(logic [SW-1:0] v, logic [NW-1:0] n);
        logic [SW-1:0] r;
        for (int i = 0; i < SW; i++)
            r[i] = (NW'(i) < n) ? v[i] : v[n - 1'b1];
        return r;
    endfunction

    function automatic logic [SW-1:0] left_align(logic [SW-1:0] v, logic [NW-1:0] n);
        return v << (NW'(SW) - n);
    endfunction

endpackage

// File: rtl/asrx_sync.sv
`timescale 1ns/1ps
module asrx_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d = {stg_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/asrx_loss.sv
`timescale 1ns/1ps
module asrx_loss #(
    parameter int LIMIT = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic evt,
    output logic lost
);
    localparam int CW = $clog2(LIMIT + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          lost;
    } loss_t;

    loss_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else begin
            if (evt)                          st_d.cnt = '0;
            else if (st_q.cnt != CW'(LIMIT))  st_d.cnt = st_q.cnt + 1'b1;
            if (st_d.cnt == CW'(LIMIT))       st_d.lost = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lost = st_q.lost;
endmodule

// File: rtl/asrx_engine.sv
`timescale 1ns/1ps
module asrx_engine
    import asrx_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [2:0]    fmt,
    input  logic          bit_evt,
    input  logic          sd,
    input  logic          ws,
    output logic [SW-1:0] left,
    output logic [SW-1:0] right,
    output logic          valid,
    output logic          ratio_err
);
    eng_t st_d, st_q;

    always_comb begin
        logic          bnd;
        logic [SW-1:0] word;
        logic [SW-1:0] tmp;
        logic [NW-1:0] n;
        bnd  = 1'b0;
        word = '0;
        tmp  = '0;
        n    = '0;
        st_d = st_q;
        st_d.valid = 1'b0;
        if (clr) begin
            st_d = '0;
        end else if (bit_evt && !fmt_reserved(fmt)) begin
            bnd          = st_q.primed && (ws != st_q.ws_last);
            st_d.primed  = 1'b1;
            st_d.ws_last = ws;
            if (bnd) begin
                // close the half-frame that just ended
                if (fmt_is_lsb(fmt)) begin
                    word = sext(st_q.acc, lsb_bits(fmt));
                end else if (fmt == FMT_I2S24) begin
                    if (st_q.nbits < NW'(SW)) begin
                        tmp = {st_q.acc[SW-2:0], sd};
                        n   = st_q.nbits + 1'b1;
                    end else begin
                        tmp = st_q.acc;
                        n   = st_q.nbits;
                    end
                    word = left_align(tmp, n);
                end else begin
                    word = left_align(st_q.acc, st_q.nbits);
                end
                if (st_q.started) begin
                    if (st_q.hcnt < min_half(fmt)) st_d.ratio_err = 1'b1;
                    if (st_q.ws_last == left_ws(fmt)) begin
                        st_d.left_hold = word;
                        st_d.have_left = 1'b1;
                    end else if (st_q.have_left) begin
                        st_d.left      = st_q.left_hold;
                        st_d.right     = word;
                        st_d.valid     = 1'b1;
                        st_d.have_left = 1'b0;
                    end
                end
                st_d.started = 1'b1;
                st_d.hcnt    = HW'(1);
                // open the next half-frame
                if (fmt_is_lsb(fmt)) begin
                    st_d.acc = {st_q.acc[SW-2:0], sd};
                end else if (fmt == FMT_I2S24) begin
                    st_d.acc   = '0;
                    st_d.nbits = '0;
                end else begin
                    st_d.acc   = {{(SW-1){1'b0}}, sd};
                    st_d.nbits = NW'(1);
                end
            end else begin
                if (st_q.hcnt != '1) st_d.hcnt = st_q.hcnt + 1'b1;
                if (fmt_is_lsb(fmt)) begin
                    st_d.acc = {st_q.acc[SW-2:0], sd};
                end else if (st_q.nbits < NW'(SW)) begin
                    st_d.acc   = {st_q.acc[SW-2:0], sd};
                    st_d.nbits = st_q.nbits + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign left      = st_q.left;
    assign right     = st_q.right;
    assign valid     = st_q.valid;
    assign ratio_err = st_q.ratio_err;
endmodule

// File: rtl/audio_serial_rx.sv
`timescale 1ns/1ps
module audio_serial_rx
    import asrx_pkg::*;
#(
    parameter int LOSS_CYCLES = 128,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwrdn,
    input  logic [2:0]    fmt_sel,
    input  logic          sck_in,
    input  logic          ws_in,
    input  logic          sd_in,
    output logic [SW-1:0] left_o,
    output logic [SW-1:0] right_o,
    output logic          valid_o,
    output logic          ratio_err_o,
    output logic          clk_loss_o
);
    logic [2:0] pins_s;
    logic       sck_s, ws_s, sd_s;
    logic [2:0] fmt_d, fmt_q;
    logic       sckp_d, sckp_q;
    logic       bit_evt;

    asrx_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({sck_in, ws_in, sd_in}),
        .dout  (pins_s)
    );
    assign {sck_s, ws_s, sd_s} = pins_s;

    always_comb begin
        fmt_d  = pwrdn ? fmt_sel : fmt_q;   // format lock
        sckp_d = sck_s;                     // tracks even in power-down
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fmt_q  <= FMT_LSB16;
            sckp_q <= 1'b0;
        end else begin
            fmt_q  <= fmt_d;
            sckp_q <= sckp_d;
        end
    end

    assign bit_evt = sck_s & ~sckp_q;

    asrx_engine u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (pwrdn),
        .fmt       (fmt_q),
        .bit_evt   (bit_evt),
        .sd        (sd_s),
        .ws        (ws_s),
        .left      (left_o),
        .right     (right_o),
        .valid     (valid_o),
        .ratio_err (ratio_err_o)
    );

    asrx_loss #(.LIMIT(LOSS_CYCLES)) u_loss (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (pwrdn),
        .evt   (bit_evt),
        .lost  (clk_loss_o)
    );
endmodule

// File: rtl/asrx_chk.sv
`timescale 1ns/1ps
module asrx_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        pwrdn,
    input logic [2:0]  fmt_q,
    input logic        valid,
    input logic [23:0] left,
    input logic [23:0] right,
    input logic        ratio_err,
    input logic        clk_loss
);
    // R1: one-cycle valid strobe
    a_r1_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    // R10: power-down silences outputs and flags
    a_r10_pwrdn_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        pwrdn |=> (!valid && left == '0 && right == '0 && !ratio_err && !clk_loss));

    // R6: latched format moves only after a power-down cycle
    a_r6_fmt_locked: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pwrdn) |-> $stable(fmt_q));

    // R7: reserved format keeps the block silent
    a_r7_reserved_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_q > 3'd4) |-> (!valid && left == '0 && right == '0));

    // R8: ratio flag is sticky while running
    a_r8_ratio_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ratio_err) && !$past(pwrdn)) |-> ratio_err);

    // R9: clock-loss flag is sticky while running
    a_r9_loss_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clk_loss) && !$past(pwrdn)) |-> clk_loss);
endmodule

bind audio_serial_rx asrx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwrdn     (pwrdn),
    .fmt_q     (fmt_q),
    .valid     (valid_o),
    .left      (left_o),
    .right     (right_o),
    .ratio_err (ratio_err_o),
    .clk_loss  (clk_loss_o)
);

// File: tb/sim_audio_serial_rx.sv
`timescale 1ns/1ps
module sim_audio_serial_rx;
    localparam int LOSS = 128;

    typedef struct packed {
        logic [2:0]  fmt;
        logic [4:0]  dw;
        logic [7:0]  hl;
        logic [23:0] l0;
        logic [23:0] r0;
        logic [23:0] l1;
        logic [23:0] r1;
    } vec_t;

    // R2 codes: 0 LSB16, 1 LSB20, 2 MSB, 3 I2S, 4 LSB24
    localparam vec_t VECS [8] = '{
        '{3'd0, 5'd16, 8'd16, 24'h008001, 24'h007FFE, 24'h000001, 24'h00FFFF},
        '{3'd1, 5'd20, 8'd32, 24'h080000, 24'h07FFFF, 24'h012345, 24'h0ABCDE},
        '{3'd4, 5'd24, 8'd32, 24'h800001, 24'h123456, 24'h7FFFFF, 24'hFEDCBA},
        '{3'd2, 5'd24, 8'd32, 24'hA5A5A5, 24'h5A5A5A, 24'h000001, 24'h800000},
        '{3'd2, 5'd20, 8'd24, 24'h0ABCDE, 24'h013579, 24'h0FFFFF, 24'h000001},
        '{3'd3, 5'd24, 8'd32, 24'hC0FFEE, 24'h012345, 24'h800000, 24'h7FFFFF},
        '{3'd3, 5'd16, 8'd16, 24'h001234, 24'h00FEDC, 24'h008000, 24'h000001},
        '{3'd0, 5'd16, 8'd32, 24'h001357, 24'h00F000, 24'h000FF0, 24'h008888}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwrdn = 1'b1;
    logic [2:0]  fmt_sel = 3'd0;
    logic        sck = 1'b0, ws = 1'b0, sd = 1'b0;
    logic [23:0] left_o, right_o;
    logic        valid_o, ratio_err_o, clk_loss_o;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;
    logic        rx_clr = 1'b0;
    int          rx_n = 0;
    logic [23:0] rx_l [0:7];
    logic [23:0] rx_r [0:7];

    audio_serial_rx #(.LOSS_CYCLES(LOSS)) u0 (
        .clk(clk), .rst_n(rst_n), .pwrdn(pwrdn), .fmt_sel(fmt_sel),
        .sck_in(sck), .ws_in(ws), .sd_in(sd),
        .left_o(left_o), .right_o(right_o), .valid_o(valid_o),
        .ratio_err_o(ratio_err_o), .clk_loss_o(clk_loss_o)
    );

    always #2.5 clk = ~clk;

    always @(negedge clk) begin
        if (rx_clr) rx_n <= 0;
        else if (valid_o) begin
            if (rx_n < 8) begin
                rx_l[rx_n] <= left_o;
                rx_r[rx_n] <= right_o;
            end
            rx_n <= rx_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send_bit(input logic w, input logic d);
        sck = 1'b0; ws = w; sd = d;
        tick(4);
        sck = 1'b1;
        tick(4);
    endtask

    function automatic logic hbit(input int fmt, input int dw, input int hl, input int k,
                                  input logic [23:0] cur, input logic [23:0] prev);
        if (fmt == 0 || fmt == 1 || fmt == 4)
            return (k >= hl - dw) ? cur[hl-1-k] : 1'b0;
        if (fmt == 3) begin
            if (k == 0) return prev[0];
            return (k - 1 < dw) ? cur[dw-k] : 1'b0;
        end
        return (k < dw) ? cur[dw-1-k] : 1'b0;
    endfunction

    task automatic send_half(input vec_t v, input bit is_left, input logic [23:0] cur, input logic [23:0] prev);
        logic w;
        w = (v.fmt == 3'd3) ? !is_left : is_left;
        for (int k = 0; k < int'(v.hl); k++)
            send_bit(w, hbit(int'(v.fmt), int'(v.dw), int'(v.hl), k, cur, prev));
    endtask

    task automatic send_stream(input vec_t v);
        send_half(v, 1'b0, 24'h0, 24'h0);   // partial lead-in, discarded (R10)
        send_half(v, 1'b1, v.l0, 24'h0);
        send_half(v, 1'b0, v.r0, v.l0);
        send_half(v, 1'b1, v.l1, v.r0);
        send_half(v, 1'b0, v.r1, v.l1);
        send_half(v, 1'b1, 24'h0, v.r1);
        sck = 1'b0;
    endtask

    function automatic logic [23:0] exp_val(input int fmt, input int dw, input logic [23:0] v);
        logic [23:0] r;
        if (fmt == 0 || fmt == 1 || fmt == 4) begin
            for (int i = 0; i < 24; i++) r[i] = (i < dw) ? v[i] : v[dw-1];
        end else begin
            r = v << (24 - dw);
        end
        return r;
    endfunction

    task automatic start_fmt(input logic [2:0] f);
        pwrdn = 1'b1; fmt_sel = f;
        tick(3);
        rx_clr = 1'b1;
        pwrdn = 1'b0;
        tick(1);
        rx_clr = 1'b0;
        tick(1);
    endtask

    task automatic run_vec(input vec_t v);
        string tag;
        int f, d;
        f = int'(v.fmt); d = int'(v.dw);
        tag = (f == 2) ? "R4" : (f == 3) ? "R5" : "R3";
        start_fmt(v.fmt);
        send_stream(v);
        tick(6);
        check(rx_n == 2, "R1 R2 R10 pair count", rx_n, 2);
        check(rx_l[0] == exp_val(f, d, v.l0), tag, rx_l[0], exp_val(f, d, v.l0));
        check(rx_r[0] == exp_val(f, d, v.r0), tag, rx_r[0], exp_val(f, d, v.r0));
        check(rx_l[1] == exp_val(f, d, v.l1), tag, rx_l[1], exp_val(f, d, v.l1));
        check(rx_r[1] == exp_val(f, d, v.r1), tag, rx_r[1], exp_val(f, d, v.r1));
        check(ratio_err_o == 1'b0, "R8 no error at legal ratio", ratio_err_o, 0);
    endtask

    initial begin
        vec_t v;
        tick(3);
        // R10: reset state
        check(left_o == 0 && right_o == 0, "R10 reset samples", left_o, 0);
        check(valid_o == 0, "R10 reset valid", valid_o, 0);
        check(ratio_err_o == 0 && clk_loss_o == 0, "R10 reset flags", {ratio_err_o, clk_loss_o}, 0);
        rst_n = 1'b1;
        tick(2);

        for (int i = 0; i < 8; i++) run_vec(VECS[i]);

        // R6: live format change is ignored
        v = VECS[0];
        start_fmt(3'd0);
        fmt_sel = 3'd2;
        send_stream(v);
        tick(6);
        check(rx_n == 2, "R6 count with locked format", rx_n, 2);
        check(rx_l[0] == exp_val(0, 16, v.l0), "R6 locked decode", rx_l[0], exp_val(0, 16, v.l0));

        // R7: reserved code
        v = '{3'd5, 5'd24, 8'd32, 24'h123456, 24'h654321, 24'h111111, 24'h222222};
        start_fmt(3'd5);
        send_stream(v);
        tick(6);
        check(rx_n == 0, "R7 no pairs", rx_n, 0);
        check(left_o == 0 && right_o == 0, "R7 outputs zero", left_o | right_o, 0);

        // R8: short halves for 24-bit MSB and 20-bit LSB
        v = '{3'd2, 5'd24, 8'd16, 24'h00ABCD, 24'h001234, 24'h00FFFF, 24'h000001};
        start_fmt(3'd2);
        send_stream(v);
        tick(6);
        check(ratio_err_o == 1'b1, "R8 MSB half of 16", ratio_err_o, 1);
        pwrdn = 1'b1;
        tick(2);
        check(ratio_err_o == 1'b0, "R8 cleared by power-down", ratio_err_o, 0);
        v = '{3'd1, 5'd16, 8'd16, 24'h001111, 24'h002222, 24'h003333, 24'h004444};
        start_fmt(3'd1);
        send_stream(v);
        tick(6);
        check(ratio_err_o == 1'b1, "R8 LSB20 half of 16", ratio_err_o, 1);

        // R9: clock loss
        start_fmt(3'd0);
        send_stream(VECS[0]);
        tick(6);
        check(clk_loss_o == 1'b0, "R9 running clock", clk_loss_o, 0);
        tick(LOSS + 10);
        check(clk_loss_o == 1'b1, "R9 stopped clock", clk_loss_o, 1);
        tick(20);
        check(clk_loss_o == 1'b1, "R9 flag sticky", clk_loss_o, 1);
        check(left_o == exp_val(0, 16, VECS[0].l1), "R1 outputs hold", left_o, exp_val(0, 16, VECS[0].l1));
        pwrdn = 1'b1;
        tick(2);
        check(clk_loss_o == 1'b0, "R10 power-down clears loss", clk_loss_o, 0);
        check(left_o == 0 && right_o == 0, "R10 power-down clears samples", left_o | right_o, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule